// File: doc/BRIEF.md
# Serial EEPROM Page Write Buffer with Timed Commit

This block sits behind the protocol engine of a two-wire serial EEPROM. For one write transaction it gathers the incoming data bytes into an eight-byte page buffer and records which of the eight slots hold data. The first accepted byte of a transaction fixes the page and the starting slot. Each later byte goes into the next slot, and the slot number wraps inside the page. When the transaction ends with a stop, the buffered bytes are written into the memory array one slot per clock. A busy phase of fixed length, set by a parameter, follows the stop and stands in for the nonvolatile programming time.

A write-protect input is captured at the stop. A parameter selects what it covers. In the whole-array variant, protect high drops every byte. In the upper-half variant, it drops only bytes whose address has the most significant bit set. When bytes are dropped, the busy phase still runs, so acknowledge polling upstream sees the same timing.

The byte input is a valid/ready stream. `ld_ready` is low for the whole busy phase. A byte offered while `ld_ready` is low is not taken, and the producer must hold `ld_valid`, `ld_addr` and `ld_data` steady until a cycle in which both `ld_valid` and `ld_ready` are high. The start and stop strobes are single-cycle pulses and are ignored while busy. The memory port is a plain write strobe with address and data.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset, `busy` is 0, `ld_ready` is 1 and `mem_we` is 0.
- R2: The first byte accepted after a start, or after a completed stop, sets the page to `ld_addr[ADDR_W-1:3]` and the slot to `ld_addr[2:0]`. Every later byte of the same transaction goes to the previous slot plus one, and its `ld_addr` is ignored.
- R3: After slot 7 the next byte goes to slot 0 of the same page, and the page bits never change.
- R4: When more than eight bytes arrive, a later byte replaces the earlier byte in the same slot, so the commit writes the last byte received for each slot.
- R5: A stop while not busy, with at least one buffered byte, raises `busy` on the next cycle. `busy` then stays high for exactly `WR_CYCLES` cycles.
- R6: In busy cycle i, counting from 0, for i from 0 to 7, `mem_we` is high exactly when slot i holds a byte and that byte is not protected. In that cycle `mem_addr` is `{page, i[2:0]}` and `mem_wdata` is the last byte stored in slot i. For i of 8 or more, `mem_we` is low.
- R7: A start clears all buffered bytes. A stop with no buffered byte, such as a dummy write, causes no write and no busy phase.
- R8: While `busy` is high, `ld_ready` is low and start and stop pulses have no effect.
- R9: `wp` is sampled on the stop cycle. With `UPPER_ONLY`=0 and `wp` high, no byte is written. With `UPPER_ONLY`=1 and `wp` high, bytes whose address MSB is 1 are not written. In both cases the busy phase still runs for its full length.
- R10: A change on `wp` after the stop does not alter the writes of the commit already under way.
- R11: `mem_we` is never high outside the busy phase, so nothing is programmed before the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Data byte offered |
| ld_ready | output | 1 | Data byte can be taken (low while busy) |
| ld_addr | input | ADDR_W | Word address of the byte |
| ld_data | input | 8 | Data byte |
| start_i | input | 1 | Start-of-transaction pulse |
| stop_i | input | 1 | Stop pulse |
| wp | input | 1 | Write-protect pin |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Write cycle in progress |

## Verification
The bench builds two instances from the same stimulus. One is a 256-byte array (`ADDR_W`=8) with upper-half protection. The other is a 128-byte array (`ADDR_W`=7) with whole-array protection. Both use `WR_CYCLES`=12. With these settings, one protected commit shows both protection variants side by side on the same page. A 12-cycle busy phase is long enough to cover all eight slot writes and several idle busy cycles, and it lets the bench show that the stream is held off and that start and stop pulses are dropped while busy.

// File: rtl/eeprom_pb_pkg.sv
package eeprom_pb_pkg;
  localparam int SLOT_W     = 3;
  localparam int PAGE_BYTES = 1 << SLOT_W;
  typedef logic [7:0]        byte_t;
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/pb_slot_store.sv
module pb_slot_store
  import eeprom_pb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_i,
  input  logic                    end_i,
  input  logic                    load_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  byte_t                   data_i,
  input  slot_t                   rd_slot_i,
  output logic [ADDR_W-SLOT_W-1:0] page_o,
  output logic [PAGE_BYTES-1:0]   mask_o,
  output byte_t                   rd_data_o
);
  byte_t                    slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]    mask_q;
  logic [ADDR_W-SLOT_W-1:0] page_q;
  slot_t                    ptr_q;
  logic                     open_q;
  slot_t                    wr_slot;

  assign wr_slot = open_q ? ptr_q : addr_i[SLOT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      page_q <= '0;
      ptr_q  <= '0;
      open_q <= 1'b0;
    end else if (clear_i) begin
      mask_q <= '0;
      open_q <= 1'b0;
    end else if (end_i) begin
      open_q <= 1'b0;
    end else if (load_i) begin
      if (!open_q) page_q <= addr_i[ADDR_W-1:SLOT_W];
      open_q          <= 1'b1;
      mask_q[wr_slot] <= 1'b1;
      ptr_q           <= wr_slot + slot_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (load_i && !clear_i && !end_i) slot_q[wr_slot] <= data_i;
  end

  assign page_o    = page_q;
  assign mask_o    = mask_q;
  assign rd_data_o = slot_q[rd_slot_i];
endmodule

// File: rtl/pb_protect.sv
module pb_protect #(
  parameter bit UPPER_ONLY = 1'b1
) (
  input  logic wp_i,
  input  logic addr_msb_i,
  output logic blocked_o
);
  generate
    if (UPPER_ONLY) begin : g_upper
      assign blocked_o = wp_i & addr_msb_i;
    end else begin : g_whole
      logic unused_msb;
      assign unused_msb = addr_msb_i;
      assign blocked_o  = wp_i;
    end
  endgenerate
endmodule

// File: rtl/pb_commit_timer.sv
module pb_commit_timer
  import eeprom_pb_pkg::*;
#(
  parameter int WR_CYCLES = 16,
  localparam int CW = $clog2(WR_CYCLES + 1),
  localparam int IW = $clog2(PAGE_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [IW-1:0] idx_o
);
  logic [CW-1:0] left_q;
  logic [IW-1:0] idx_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (go_i) begin
        busy_q <= 1'b1;
        left_q <= CW'(WR_CYCLES - 1);
        idx_q  <= '0;
      end
    end else begin
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - CW'(1);
      if (idx_q != IW'(PAGE_BYTES)) idx_q <= idx_q + IW'(1);
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (left_q == '0);
  assign idx_o  = idx_q;
endmodule

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit
  import eeprom_pb_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int WR_CYCLES  = 16,
  parameter bit UPPER_ONLY = 1'b1,
  localparam int IW = $clog2(PAGE_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              wp,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy
);
  generate
    if (WR_CYCLES < PAGE_BYTES) begin : g_bad_len
      $error("WR_CYCLES must cover one write per page slot");
    end
  endgenerate

  logic [ADDR_W-SLOT_W-1:0] page;
  logic [PAGE_BYTES-1:0]    mask;
  logic [IW-1:0]            idx;
  logic                     done, go, start_ok, stop_ok, take;
  logic                     wp_q, blocked, in_page;
  byte_t                    rd_data;

  assign ld_ready = !busy;
  assign start_ok = start_i && !busy;
  assign stop_ok  = stop_i && !busy && !start_i;
  assign take     = ld_valid && ld_ready && !start_i && !stop_i;
  assign go       = stop_ok && (mask != '0);

  pb_slot_store #(.ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_ok || done),
    .end_i    (stop_ok),
    .load_i   (take),
    .addr_i   (ld_addr),
    .data_i   (ld_data),
    .rd_slot_i(idx[SLOT_W-1:0]),
    .page_o   (page),
    .mask_o   (mask),
    .rd_data_o(rd_data)
  );

  pb_commit_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (go),
    .busy_o(busy),
    .done_o(done),
    .idx_o (idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  wp_q <= 1'b0;
    else if (go) wp_q <= wp;
  end

  pb_protect #(.UPPER_ONLY(UPPER_ONLY)) u_prot (
    .wp_i      (wp_q),
    .addr_msb_i(page[ADDR_W-SLOT_W-1]),
    .blocked_o (blocked)
  );

  assign in_page   = (idx < IW'(PAGE_BYTES));
  assign mem_addr  = {page, idx[SLOT_W-1:0]};
  assign mem_wdata = rd_data;
  assign mem_we    = busy && in_page && mask[idx[SLOT_W-1:0]] && !blocked;
endmodule

// File: rtl/eeprom_page_commit_chk.sv
module eeprom_page_commit_chk #(
  parameter int ADDR_W    = 8,
  parameter int WR_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_ready,
  input logic              stop_i,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy
);
  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R11
  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_ready); // R8
  AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_i)); // R5
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == WR_CYCLES); // R5
  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> mem_addr[ADDR_W-1:3] == $past(mem_addr[ADDR_W-1:3])); // R10
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr[2:0] == $past(mem_addr[2:0]) + 3'd1); // R6
endmodule

bind eeprom_page_commit eeprom_page_commit_chk #(
  .ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_ready(ld_ready), .stop_i(stop_i),
  .mem_we(mem_we), .mem_addr(mem_addr), .busy(busy)
);

// File: tb/tb_eeprom_page_commit.sv
module tb_eeprom_page_commit;
  localparam int WRC = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       ld_valid = 0, start_i = 0, stop_i = 0, wp = 0;
  logic [7:0] ld_addr = 0, ld_data = 0;

  logic       rdy_b, we_b, busy_b, rdy_s, we_s, busy_s;
  logic [7:0] addr_b, data_b, data_s;
  logic [6:0] addr_s;

  eeprom_page_commit #(.ADDR_W(8), .WR_CYCLES(WRC), .UPPER_ONLY(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(rdy_b),
    .ld_addr(ld_addr), .ld_data(ld_data), .start_i(start_i), .stop_i(stop_i),
    .wp(wp), .mem_we(we_b), .mem_addr(addr_b), .mem_wdata(data_b), .busy(busy_b));

  eeprom_page_commit #(.ADDR_W(7), .WR_CYCLES(WRC), .UPPER_ONLY(1'b0)) dut_small (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(rdy_s),
    .ld_addr(ld_addr[6:0]), .ld_data(ld_data), .start_i(start_i), .stop_i(stop_i),
    .wp(wp), .mem_we(we_s), .mem_addr(addr_s), .mem_wdata(data_s), .busy(busy_s));

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit         m_busy, m_have, m_wp, m_acc;
  int         m_left, m_idx, m_ptr;
  bit [7:0]   m_mask;
  logic [7:0] m_buf [8];
  logic [4:0] m_page;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_have = 0; m_wp = 0; m_acc = 0;
      m_left = 0; m_idx = 0; m_ptr = 0; m_mask = 0; m_page = 0;
    end else begin
      m_acc = 0;
      if (m_busy) begin
        m_idx++;
        m_left--;
        if (m_left == 0) begin m_busy = 0; m_mask = 0; m_have = 0; end
      end else if (start_i) begin
        m_mask = 0; m_have = 0;
      end else if (stop_i) begin
        if (m_mask != 0) begin m_busy = 1; m_left = WRC; m_idx = 0; m_wp = wp; end
        m_have = 0;
      end else if (ld_valid) begin
        m_acc = 1;
        if (!m_have) begin m_page = ld_addr[7:3]; m_ptr = ld_addr[2:0]; m_have = 1; end
        m_buf[m_ptr] = ld_data;
        m_mask[m_ptr] = 1;
        m_ptr = (m_ptr + 1) % 8;
      end
    end
  end

  int nw_b, nw_s, nbusy;
  always @(negedge clk) begin
    if (rst_n) begin
      bit eb, es;
      eb = m_busy && m_idx < 8 && m_mask[m_idx % 8] && !(m_wp && m_page[4]);
      es = m_busy && m_idx < 8 && m_mask[m_idx % 8] && !m_wp;
      chk(rdy_b == !m_busy && rdy_s == !m_busy, "R8", "ld_ready", rdy_b, !m_busy);
      chk(busy_b == m_busy && busy_s == m_busy, "R5", "busy", busy_b, m_busy);
      chk(we_b == eb, "R6", "mem_we large", we_b, eb);
      chk(we_s == es, "R9", "mem_we small", we_s, es);
      if (eb) begin
        chk(addr_b == {m_page, 3'(m_idx)}, "R6", "mem_addr", addr_b, {m_page, 3'(m_idx)});
        chk(data_b == m_buf[m_idx], "R4", "mem_wdata", data_b, m_buf[m_idx]);
      end
      if (es) chk(addr_s == {m_page[3:0], 3'(m_idx)}, "R6", "small addr", addr_s,
                  {m_page[3:0], 3'(m_idx)});
      if (we_b) nw_b++;
      if (we_s) nw_s++;
      if (busy_b) nbusy++;
    end
  end

  task automatic pulse_start(); @(negedge clk); start_i = 1; @(negedge clk); start_i = 0; endtask
  task automatic pulse_stop();  @(negedge clk); stop_i = 1;  @(negedge clk); stop_i = 0;  endtask
  task automatic load(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); ld_valid = 1; ld_addr = a; ld_data = d;
    do @(negedge clk); while (!m_acc);
    ld_valid = 0;
  endtask
  task automatic wait_idle();
    do @(negedge clk); while (m_busy);
    @(negedge clk);
  endtask
  task automatic clr(); nw_b = 0; nw_s = 0; nbusy = 0; endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_b == 0 && rdy_b == 1 && we_b == 0, "R1", "reset state", busy_b, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy_b == 0 && rdy_b == 1 && we_b == 0 && we_s == 0, "R1", "after reset", we_b, 0);

    // R2 later addresses ignored; R11 nothing before stop; R5 busy length
    clr(); pulse_start();
    load(8'h85, 8'hA0); load(8'h13, 8'hA1); load(8'h00, 8'hA2);
    repeat (3) @(negedge clk);
    chk(nw_b == 0 && busy_b == 0, "R11", "writes before stop", nw_b, 0);
    pulse_stop(); wait_idle();
    chk(nw_b == 3 && nw_s == 3, "R2", "write count", nw_b, 3);
    chk(nbusy == WRC, "R5", "busy cycles", nbusy, WRC);

    // R3 wrap within page
    clr(); pulse_start();
    for (int i = 0; i < 4; i++) load(8'h9E, 8'h30 + 8'(i));
    pulse_stop(); wait_idle();
    chk(nw_b == 4, "R3", "wrap write count", nw_b, 4);

    // R4 eleven bytes, last eight kept
    clr(); pulse_start();
    for (int i = 0; i < 11; i++) load(8'hA0, 8'h50 + 8'(i));
    pulse_stop(); wait_idle();
    chk(nw_b == 8 && nw_s == 8, "R4", "overflow write count", nw_b, 8);

    // R7 start clears buffered bytes
    clr(); pulse_start(); load(8'h11, 8'h01); load(8'h11, 8'h02);
    pulse_start(); pulse_stop(); repeat (4) @(negedge clk);
    chk(nbusy == 0 && nw_b == 0, "R7", "cleared then stop", nbusy, 0);

    // R7 dummy write
    clr(); pulse_start(); pulse_stop(); repeat (4) @(negedge clk);
    chk(nbusy == 0 && nw_s == 0, "R7", "dummy write", nbusy, 0);

    // R9 protected upper half on both variants
    clr(); wp = 1; pulse_start(); load(8'h90, 8'hC1); load(8'h90, 8'hC2);
    pulse_stop(); wait_idle();
    chk(nw_b == 0 && nw_s == 0, "R9", "upper protected", nw_b, 0);
    chk(nbusy == WRC, "R9", "busy still runs", nbusy, WRC);

    // R9 lower half: large writes, small blocked
    clr(); pulse_start();
    for (int i = 0; i < 3; i++) load(8'h30, 8'hD0 + 8'(i));
    pulse_stop(); wait_idle();
    chk(nw_b == 3, "R9", "lower large", nw_b, 3);
    chk(nw_s == 0, "R9", "lower small", nw_s, 0);

    // R10 wp raised mid-commit
    clr(); wp = 0; pulse_start(); load(8'hC0, 8'hE0); load(8'hC0, 8'hE1);
    pulse_stop(); wp = 1; wait_idle(); wp = 0;
    chk(nw_b == 2 && nw_s == 2, "R10", "wp during busy", nw_b, 2);

    // R8 start, stop and data held off while busy
    clr(); pulse_start(); load(8'h40, 8'h77); pulse_stop();
    pulse_start(); pulse_stop();
    chk(busy_b == 1, "R8", "still busy", busy_b, 1);
    load(8'h48, 8'h55);
    chk(nbusy == WRC, "R8", "accepted after busy", nbusy, WRC);
    pulse_stop(); wait_idle();
    chk(nw_b == 2, "R8", "held byte committed", nw_b, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule